// File: doc/BRIEF.md
# Beam-Synchronised Command Sequencer

This block is a small coprocessor that runs a list of commands held in memory. The list is timed against the video beam. Each command is two 16-bit words, fetched one at a time through a request/grant memory port. A command either writes a 16-bit value to a hardware register over a simple register-bus output, or compares the current beam position with a target. When the target is not yet reached, a compare command either stalls the list (WAIT) or lets it continue (SKIP). A WAIT can also require the blitter to be idle.

A pulse on `frame_start` restarts the list from the address on `list_base`. This works from any state, so the list runs again in step with every frame. A WAIT whose target lies beyond the last beam position of the frame parks the sequencer until the next restart.

The controller has five states:
- `ST_IDLE`: after reset, until the first frame pulse.
- `ST_LOAD_A`: fetches the first word.
- `ST_LOAD_B`: fetches the second word.
- `ST_EXEC`: acts on the command.
- `ST_WAIT`: stalls on the beam and blitter condition.

The transitions are:
- any state → `ST_LOAD_A` on `frame_start`.
- `ST_LOAD_A` → `ST_LOAD_B` on a grant.
- `ST_LOAD_B` → `ST_EXEC` on a grant.
- `ST_EXEC` → `ST_LOAD_A` after a MOVE, after a SKIP, or after a WAIT whose condition already holds.
- `ST_EXEC` → `ST_WAIT` for a WAIT whose condition does not hold.
- `ST_WAIT` → `ST_LOAD_A` once the condition holds.

Top module: `beam_cmd_engine`

## Requirements
- R1: After reset, `mem_req` and `reg_we` stay low until the first `frame_start` pulse.
- R2: In the cycle after a `frame_start` pulse, `mem_req` is high with `mem_addr` equal to the `list_base` sampled with the pulse. This holds from every state, including a stalled WAIT.
- R3: While `mem_req` is high and `mem_grant` is low, the request stays high and `mem_addr` stays unchanged in the next cycle. Each grant consumes exactly one word.
- R4: The words of a list are fetched from consecutive word addresses, first word before second word.
- R5: A command whose first word has bit 0 = 0 is a MOVE. In the cycle after the second word is granted, it drives `reg_we` high for one cycle, with `reg_addr` = first word bits [8:1] and `reg_wdata` = second word. `mem_req` is low in that cycle.
- R6: A command whose first word has bit 0 = 1 compares positions.
  - The beam key is {beam_v[7:0], beam_h[7:1]}. The target key is first word bits [15:1].
  - The mask is {1, second word bits [14:1]}, so vertical bit 7 is always compared.
  - The condition on position is (beam key AND mask) ≥ (target key AND mask).
- R7: If second-word bit 15 is 0, the compare command also requires `blit_busy` = 0. If bit 15 is 1, the blitter is ignored.
- R8: A WAIT (second-word bit 0 = 0) whose condition is false stalls: no fetch and no write occur until the condition holds. The list then proceeds with the next command.
- R9: A SKIP (second-word bit 0 = 1) never stalls. If its condition holds, the next command is passed over without being fetched. If it does not hold, the next command runs normally.
- R10: A WAIT whose target is never reached keeps the block silent until the next `frame_start`, after which the list runs again.
- R11: `reg_we` is never high in two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse: restart the list |
| list_base | input | AW | Word address of the first command |
| beam_v | input | 8 | Vertical beam counter |
| beam_h | input | 8 | Horizontal beam counter |
| blit_busy | input | 1 | Blitter operation in progress |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | AW | Word address of the fetch |
| mem_grant | input | 1 | Grant; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 16 | Fetched word |
| reg_we | output | 1 | Register write strobe |
| reg_addr | output | RAW | Register address of the write |
| reg_wdata | output | 16 | Register write data |

## Verification
A wrong list pointer shows up at `mem_addr` on the very next fetch request, which is one cycle after a restart or a grant. The bench compares the granted addresses against the expected sequence, including the two-word jump of a taken SKIP. A wrong decision in the compare or blitter logic shows within a few cycles as a missing or extra register write. A write appears about five cycles after a restart when the condition holds, while a stall keeps `mem_req` low for as long as the bench holds the beam. A stuck or wrongly encoded state appears as a request that never drops, or a write strobe lasting more than one cycle.

// File: rtl/bce_pkg.sv
package bce_pkg;
    localparam int WORD_W = 16;
    localparam int VPOS_W = 8;
    localparam int HPOS_W = 8;
    // horizontal position is compared at half resolution (bit 0 dropped)
    localparam int KEY_W  = VPOS_W + HPOS_W - 1;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOAD_A,
        ST_LOAD_B,
        ST_EXEC,
        ST_WAIT
    } seq_state_e;

    typedef struct packed {
        logic             is_move;
        logic             is_skip;
        logic             blit_ignore;
        logic [KEY_W-1:0] target;
        logic [KEY_W-1:0] mask;
    } cmd_fields_t;
endpackage

// File: rtl/bce_decode.sv
module bce_decode
    import bce_pkg::*;
#(
    parameter int RAW = 8
) (
    input  logic [WORD_W-1:0] word_a,
    input  logic [WORD_W-1:0] word_b,
    output cmd_fields_t       fields,
    output logic [RAW-1:0]    reg_addr
);
    always_comb begin
        fields.is_move     = ~word_a[0];
        fields.is_skip     = word_b[0];
        fields.blit_ignore = word_b[WORD_W-1];
        fields.target      = word_a[WORD_W-1:1];
        fields.mask        = {1'b1, word_b[WORD_W-2:1]};
        reg_addr           = word_a[RAW:1];
    end
endmodule

// File: rtl/bce_beam_cmp.sv
module bce_beam_cmp #(
    parameter int KW = 15
) (
    input  logic [KW-1:0] beam_key,
    input  logic [KW-1:0] target,
    input  logic [KW-1:0] mask,
    output logic          reached
);
    logic [KW-1:0] beam_m;
    logic [KW-1:0] targ_m;

    always_comb begin
        beam_m  = beam_key & mask;
        targ_m  = target & mask;
        reached = (beam_m >= targ_m);
    end
endmodule

// File: rtl/bce_ptr.sv
module bce_ptr #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] base,
    input  logic          step,
    input  logic          jump,
    output logic [AW-1:0] ptr
);
    localparam logic [AW-1:0] ONE_WORD = AW'(1);
    localparam logic [AW-1:0] ONE_CMD  = AW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ptr <= '0;
        else if (load)
            ptr <= base;
        else if (step)
            ptr <= ptr + ONE_WORD;
        else if (jump)
            ptr <= ptr + ONE_CMD;
    end
endmodule

// File: rtl/beam_cmd_engine.sv
module beam_cmd_engine
    import bce_pkg::*;
#(
    parameter int AW  = 16,
    parameter int RAW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic [AW-1:0]     list_base,
    input  logic [VPOS_W-1:0] beam_v,
    input  logic [HPOS_W-1:0] beam_h,
    input  logic              blit_busy,
    output logic              mem_req,
    output logic [AW-1:0]     mem_addr,
    input  logic              mem_grant,
    input  logic [WORD_W-1:0] mem_rdata,
    output logic              reg_we,
    output logic [RAW-1:0]    reg_addr,
    output logic [WORD_W-1:0] reg_wdata
);
    seq_state_e        state;
    seq_state_e        state_nx;
    logic [WORD_W-1:0] word_a;
    logic [WORD_W-1:0] word_b;
    cmd_fields_t       fields;
    logic [RAW-1:0]    dec_addr;
    logic [KEY_W-1:0]  beam_key;
    logic              pos_reached;
    logic              cond_met;
    logic [AW-1:0]     ptr;
    logic              take_word;
    logic              skip_taken;

    bce_decode #(.RAW(RAW)) u_dec (
        .word_a   (word_a),
        .word_b   (word_b),
        .fields   (fields),
        .reg_addr (dec_addr)
    );

    assign beam_key = {beam_v, beam_h[HPOS_W-1:1]};

    bce_beam_cmp #(.KW(KEY_W)) u_cmp (
        .beam_key (beam_key),
        .target   (fields.target),
        .mask     (fields.mask),
        .reached  (pos_reached)
    );

    assign cond_met   = pos_reached & (fields.blit_ignore | ~blit_busy);
    assign take_word  = mem_req & mem_grant & ~frame_start;
    assign skip_taken = (state == ST_EXEC) & ~fields.is_move & fields.is_skip
                        & cond_met & ~frame_start;

    bce_ptr #(.AW(AW)) u_ptr (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (frame_start),
        .base  (list_base),
        .step  (take_word),
        .jump  (skip_taken),
        .ptr   (ptr)
    );

    // command word capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_a <= '0;
            word_b <= '0;
        end else if (take_word) begin
            if (state == ST_LOAD_A)
                word_a <= mem_rdata;
            else
                word_b <= mem_rdata;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // transitions
    always_comb begin
        state_nx = state;
        if (frame_start) begin
            state_nx = ST_LOAD_A;
        end else begin
            unique case (state)
                ST_IDLE:   state_nx = ST_IDLE;
                ST_LOAD_A: if (mem_grant) state_nx = ST_LOAD_B;
                ST_LOAD_B: if (mem_grant) state_nx = ST_EXEC;
                ST_EXEC: begin
                    if (fields.is_move || fields.is_skip || cond_met)
                        state_nx = ST_LOAD_A;
                    else
                        state_nx = ST_WAIT;
                end
                ST_WAIT:   if (cond_met) state_nx = ST_LOAD_A;
                default:   state_nx = ST_IDLE;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req   = (state == ST_LOAD_A) || (state == ST_LOAD_B);
        mem_addr  = ptr;
        reg_we    = (state == ST_EXEC) && fields.is_move;
        reg_addr  = dec_addr;
        reg_wdata = word_b;
    end
endmodule

// File: rtl/bce_checker.sv
module bce_checker #(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic [AW-1:0] list_base,
    input  logic          mem_req,
    input  logic          mem_grant,
    input  logic [AW-1:0] mem_addr,
    input  logic          reg_we
);
    logic seen_frame;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            seen_frame <= 1'b0;
        else if (frame_start)
            seen_frame <= 1'b1;
    end

    p_quiet_before_frame_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!seen_frame && !frame_start) |=> (!mem_req && !reg_we));

    p_restart_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |=> (mem_req && mem_addr == $past(list_base)));

    p_req_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_grant && !frame_start) |=> (mem_req && $stable(mem_addr)));

    p_write_after_grant_r5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |-> ($past(mem_grant) && !mem_req));

    p_single_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);
endmodule

bind beam_cmd_engine bce_checker #(.AW(AW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (frame_start),
    .list_base   (list_base),
    .mem_req     (mem_req),
    .mem_grant   (mem_grant),
    .mem_addr    (mem_addr),
    .reg_we      (reg_we)
);

// File: tb/sim_beam_cmd_engine.sv
module sim_beam_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int AW  = 16;
    localparam int RAW = 8;
    localparam logic [15:0] HALT_A = 16'hFFFF;
    localparam logic [15:0] HALT_B = 16'hFFFE;

    // {word_a, word_b, beam_v, beam_h, blit_busy, expect_write}
    localparam int NV = 10;
    localparam logic [49:0] VECS [NV] = '{
        {16'h1021, 16'hFFFE, 8'h10, 8'h20, 1'b0, 1'b1},
        {16'h1021, 16'hFFFE, 8'h10, 8'h1E, 1'b0, 1'b0},
        {16'h1021, 16'hFFFE, 8'h11, 8'h00, 1'b0, 1'b1},
        {16'h1021, 16'hFFFE, 8'h0F, 8'hFE, 1'b0, 1'b0},
        {16'h1021, 16'hFF00, 8'h10, 8'h00, 1'b0, 1'b1},
        {16'h1021, 16'h80FE, 8'h05, 8'h40, 1'b0, 1'b1},
        {16'h1021, 16'h7FFE, 8'h20, 8'h00, 1'b1, 1'b0},
        {16'h1021, 16'h7FFE, 8'h20, 8'h00, 1'b0, 1'b1},
        {16'hFFFF, 16'hFFFE, 8'h80, 8'h80, 1'b0, 1'b0},
        {16'h8001, 16'h80FE, 8'h7F, 8'hFE, 1'b0, 1'b0}
    };

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           frame_start = 1'b0;
    logic [AW-1:0]  list_base = '0;
    logic [7:0]     beam_v = '0;
    logic [7:0]     beam_h = '0;
    logic           blit_busy = 1'b0;
    logic           mem_req;
    logic [AW-1:0]  mem_addr;
    logic           mem_grant;
    logic [15:0]    mem_rdata;
    logic           reg_we;
    logic [RAW-1:0] reg_addr;
    logic [15:0]    reg_wdata;
    logic           gnt_en = 1'b1;

    logic [15:0] mem [64];

    int checks = 0;
    int errors = 0;
    int wr_n = 0;
    int ga_n = 0;
    logic [RAW-1:0] wr_addr [64];
    logic [15:0]    wr_data [64];
    logic [AW-1:0]  ga_addr [64];
    bit  we_prev = 1'b0;
    bit  we_double = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mem_grant = mem_req & gnt_en;
    assign mem_rdata = mem[mem_addr[5:0]];

    beam_cmd_engine #(.AW(AW), .RAW(RAW)) u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .list_base   (list_base),
        .beam_v      (beam_v),
        .beam_h      (beam_h),
        .blit_busy   (blit_busy),
        .mem_req     (mem_req),
        .mem_addr    (mem_addr),
        .mem_grant   (mem_grant),
        .mem_rdata   (mem_rdata),
        .reg_we      (reg_we),
        .reg_addr    (reg_addr),
        .reg_wdata   (reg_wdata)
    );

    // port monitor
    always @(negedge clk) begin
        if (rst_n) begin
            if (reg_we) begin
                if (wr_n < 64) begin
                    wr_addr[wr_n] = reg_addr;
                    wr_data[wr_n] = reg_wdata;
                end
                wr_n = wr_n + 1;
            end
            if (mem_req && mem_grant) begin
                if (ga_n < 64) ga_addr[ga_n] = mem_addr;
                ga_n = ga_n + 1;
            end
            if (reg_we && we_prev) we_double = 1'b1;
            we_prev = reg_we;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic report();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic launch(input logic [AW-1:0] base, input logic [7:0] v,
                          input logic [7:0] h, input logic busy);
        @(negedge clk);
        frame_start = 1'b1;
        list_base   = base;
        beam_v      = v;
        beam_h      = h;
        blit_busy   = busy;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic put(input int idx, input logic [15:0] a, input logic [15:0] b);
        mem[idx]   = a;
        mem[idx+1] = b;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual %0h expected %0h", 1, 0);
        report();
    end

    initial begin
        int wb;
        int gb;
        for (int i = 0; i < 64; i++) mem[i] = 16'h0000;

        // R1: quiet after reset
        run(3);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            chk(!mem_req && !reg_we, "R1 idle after reset", {mem_req, reg_we}, 0);
        end

        // R2 + R3: restart address and held request
        put(8, 16'h0024, 16'h1111);
        put(10, 16'h0068, 16'h2222);
        put(12, HALT_A, HALT_B);
        gnt_en = 1'b0;
        @(negedge clk);
        frame_start = 1'b1;
        list_base   = 16'd8;
        @(negedge clk);
        frame_start = 1'b0;
        chk(mem_req && mem_addr == 16'd8, "R2 first fetch at base", int'(mem_addr), 8);
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(mem_req && mem_addr == 16'd8, "R3 request held", int'(mem_addr), 8);
        end
        chk(wr_n == 0, "R3 nothing taken without grant", wr_n, 0);

        // R4 + R5: two moves
        wb = wr_n;
        gb = ga_n;
        gnt_en = 1'b1;
        run(20);
        chk(wr_n - wb == 2, "R5 move count", wr_n - wb, 2);
        chk(wr_addr[wb] == 8'h12 && wr_data[wb] == 16'h1111, "R5 first move",
            {wr_addr[wb], wr_data[wb]}, 24'h121111);
        chk(wr_addr[wb+1] == 8'h34 && wr_data[wb+1] == 16'h2222, "R5 second move",
            {wr_addr[wb+1], wr_data[wb+1]}, 24'h342222);
        for (int i = 0; i < 6; i++)
            chk(ga_addr[gb+i] == AW'(8 + i), "R4 fetch address order", int'(ga_addr[gb+i]), 8 + i);

        // R10: parked on unreachable wait
        wb = wr_n;
        for (int i = 0; i < 5; i++) begin
            run(6);
            chk(!mem_req, "R10 parked no fetch", mem_req, 0);
        end
        chk(wr_n == wb, "R10 parked no write", wr_n - wb, 0);
        launch(16'd8, 8'h00, 8'h00, 1'b0);
        run(20);
        chk(wr_n - wb == 2, "R10 list reruns after restart", wr_n - wb, 2);

        // R6 R7 R8: table of compare vectors
        for (int i = 0; i < NV; i++) begin
            logic [49:0] v;
            v = VECS[i];
            put(0, v[49:34], v[33:18]);
            put(2, 16'h00AA, 16'(i));
            put(4, HALT_A, HALT_B);
            wb = wr_n;
            launch(16'd0, v[17:10], v[9:2], v[1]);
            run(20);
            chk(wr_n - wb == int'(v[0]), $sformatf("R6 compare vector %0d", i), wr_n - wb, v[0]);
            if (v[0])
                chk(wr_data[wb] == 16'(i), $sformatf("R8 data after wait vector %0d", i),
                    wr_data[wb], i);
            else
                chk(!mem_req, $sformatf("R8 stalled without fetch vector %0d", i), mem_req, 0);
        end

        // R7: blitter release lets a stalled wait proceed
        put(20, 16'h0001, 16'h7FFE);
        put(22, 16'h0010, 16'h5A5A);
        put(24, HALT_A, HALT_B);
        wb = wr_n;
        launch(16'd20, 8'h40, 8'h00, 1'b1);
        run(15);
        chk(wr_n == wb, "R7 blocked while blitter busy", wr_n - wb, 0);
        blit_busy = 1'b0;
        run(10);
        chk(wr_n - wb == 1 && wr_data[wb] == 16'h5A5A, "R7 proceeds after blitter idle",
            wr_data[wb], 16'h5A5A);

        // R9: skip taken
        put(16, 16'h0001, 16'hFFFF);
        put(18, 16'h0002, 16'hAAAA);
        put(20, 16'h0004, 16'hBBBB);
        put(22, HALT_A, HALT_B);
        wb = wr_n;
        gb = ga_n;
        launch(16'd16, 8'h10, 8'h00, 1'b0);
        run(25);
        chk(wr_n - wb == 1 && wr_addr[wb] == 8'h02, "R9 skip taken", wr_addr[wb], 8'h02);
        chk(ga_addr[gb+2] == 16'd20, "R9 skip jumps two words", int'(ga_addr[gb+2]), 20);

        // R9: skip not taken
        mem[16] = 16'h8001;
        wb = wr_n;
        launch(16'd16, 8'h10, 8'h00, 1'b0);
        run(25);
        chk(wr_n - wb == 2, "R9 skip not taken", wr_n - wb, 2);

        // R11: strobe width
        chk(!we_double, "R11 single cycle write strobe", we_double, 0);

        report();
    end
endmodule